// File: doc/BRIEF.md
# Eight-bit up/down timer with two compare channels

This block is a counter that advances one step per selected timer tick. The tick comes from one of two places. It can be a prescaled pulse supplied from outside the block, or a rising or falling edge of an asynchronous input pin, which is synchronized first. When no source is selected, the count does not move. Four operating modes choose the shape of the count:

- free-running up count with a fixed top of all-ones;
- up count that clears when it reaches compare value A;
- fast PWM;
- dual-slope up/down PWM.

Each of the two compare channels holds a buffered compare value and an active compare value. The active value is what the count is checked against. When the active value matches, the channel sets its flag and drives its output pin according to the mode.

Software reaches the state through a small word-wide register port with six addresses. Reads are combinational from the address. Writes take effect at the clock edge. An overflow flag and two match flags are gated by a mask register, and together they drive a single interrupt line.

Top module: `tc8_timer`

## Requirements
- R1: After reset, the count, both compare buffers, both active compare values, the control word, the flags and the mask are all zero. The direction is up, and both compare pins and the interrupt line are low.
- R2: The register map is as follows, and any other address reads zero:
  - address 0: the count;
  - address 1: compare buffer A;
  - address 2: compare buffer B;
  - address 3: the control word in bits [4:0], with bits [7:5] reading zero;
  - address 4: the flags in bits [2:0];
  - address 5: the mask in bits [2:0].
- R3: Control bits [2:0] select the tick source:
  - 0: none;
  - 1: the tick_i pulse;
  - 2: a rising edge of ext_i;
  - 3: a falling edge of ext_i;
  - 4 to 7: none.

  With no source selected, the count holds. An ext_i edge passes two synchronizer flops and an edge flop, so the count moves on the third rising clock edge after the pin changes.
- R4: Control bits [4:3] select the mode:
  - 0: up count, wrapping from 0xFF to 0x00;
  - 1: up count, clearing to 0x00 on the tick that finds the count equal to active compare A;
  - 2: fast PWM, an up count that wraps at 0xFF;
  - 3: up/down count with a top of 0xFF.
- R5: In mode 3, a tick at 0xFF while counting up turns the direction down and loads 0xFE. A tick at 0x00 while counting down turns the direction up and loads 0x01.
- R6: The flags are bit 0 for overflow, bit 1 for match A and bit 2 for match B.
  - In modes 0 to 2, overflow sets on a tick taken at 0xFF.
  - In mode 3, overflow sets on the turn at 0x00.
  - A match flag sets on a tick whose count equals that channel's active compare value.
- R7: Writing address 4 clears each flag whose data bit is 1. A flag set event in the same cycle wins over the clear.
- R8: irq_o is high exactly when some flag is set together with its mask bit.
- R9: In modes 0 and 1, a compare write also loads the active value at the same edge. In modes 2 and 3, the active value loads from the buffer only on a tick at top, which is 0xFF counting up.
- R10: oc_o[0] belongs to channel A and oc_o[1] to channel B.
  - Modes 0 and 1 toggle the pin on a match.
  - Mode 2 sets the pin on the tick at 0xFF and otherwise clears it on a match; the set wins if both happen on the same tick.
  - Mode 3 sets the pin on a match while counting up and clears it on a match while counting down.
- R11: A count write wins over a tick in the same cycle. It suppresses any match on that cycle and on the next tick taken after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| tick_i | input | 1 | Prescaled internal tick pulse |
| ext_i | input | 1 | Asynchronous external count pin |
| oc_o | output | 2 | Compare output pins, [0]=A, [1]=B |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- wr_en_i, addr_i and wdata_i are known on every clock edge after reset;
- mode changes arrive only through control writes;
- tick_i is a level sampled at the edge, with no pulse-width rule.

The stimulus drives every input half a period away from the sampling edge. It toggles ext_i no more than once per cycle and keeps write addresses inside the map. Random control words still cover the unused tick-source codes 4 to 7 and every mode change in the middle of a count.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_CTC  = 2'd1,
    MODE_FAST = 2'd2,
    MODE_UPDN = 2'd3
  } mode_e;

  localparam logic [2:0] SRC_NONE = 3'd0;
  localparam logic [2:0] SRC_TICK = 3'd1;
  localparam logic [2:0] SRC_RISE = 3'd2;
  localparam logic [2:0] SRC_FALL = 3'd3;

  localparam logic [2:0] ADDR_CNT  = 3'd0;
  localparam logic [2:0] ADDR_CMPA = 3'd1;
  localparam logic [2:0] ADDR_CMPB = 3'd2;
  localparam logic [2:0] ADDR_CTRL = 3'd3;
  localparam logic [2:0] ADDR_FLAG = 3'd4;
  localparam logic [2:0] ADDR_MASK = 3'd5;

  localparam int NUM_CH  = 2;
  localparam int FLG_W   = 1 + NUM_CH;
  localparam int FLG_OVF = 0;
  localparam int CTRL_W  = 5;

  function automatic logic is_pwm(mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/tc8_tick_sel.sv
module tc8_tick_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] src_i,
  input  logic       tick_i,
  input  logic       ext_i,
  output logic       adv_o
);
  import tc8_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], ext_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;
  assign fall = ~sync_q[LAST] & prev_q;

  always_comb begin
    case (src_i)
      SRC_TICK: adv_o = tick_i;
      SRC_RISE: adv_o = rise;
      SRC_FALL: adv_o = fall;
      default:  adv_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tc8_counter.sv
module tc8_counter #(
  parameter int W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  tc8_pkg::mode_e mode_i,
  input  logic [W-1:0]  cmp_top_i,
  output logic [W-1:0]  cnt_o,
  output logic          dir_up_o,
  output logic          step_o,
  output logic          top_o,
  output logic          ovf_o
);
  import tc8_pkg::*;

  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, nxt_cnt, top_val;
  logic         dir_q, nxt_dir, top_hit, ovf_hit;

  assign top_val = (mode_i == MODE_CTC) ? cmp_top_i : MAX;

  always_comb begin
    nxt_cnt = cnt_q;
    nxt_dir = dir_q;
    top_hit = 1'b0;
    ovf_hit = 1'b0;
    if (mode_i == MODE_UPDN) begin
      if (dir_q) begin
        if (cnt_q == MAX) begin
          nxt_dir = 1'b0;
          nxt_cnt = MAX - ONE;
          top_hit = 1'b1;
        end else begin
          nxt_cnt = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          nxt_dir = 1'b1;
          nxt_cnt = ONE;
          ovf_hit = 1'b1;
        end else begin
          nxt_cnt = cnt_q - ONE;
        end
      end
    end else begin
      top_hit = (cnt_q == top_val);
      ovf_hit = (cnt_q == MAX);
      nxt_cnt = (mode_i == MODE_CTC && top_hit) ? '0 : cnt_q + ONE;
    end
  end

  assign step_o = adv_i & ~wr_i;
  assign top_o  = step_o & top_hit;
  assign ovf_o  = step_o & ovf_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
    end else if (adv_i) begin
      cnt_q <= nxt_cnt;
      dir_q <= nxt_dir;
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_up_o = dir_q;
endmodule

// File: rtl/tc8_cmp_chan.sv
module tc8_cmp_chan #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  tc8_pkg::mode_e mode_i,
  input  logic           wr_buf_i,
  input  logic [W-1:0]   wdata_i,
  input  logic           step_i,
  input  logic           top_i,
  input  logic           blk_i,
  input  logic [W-1:0]   cnt_i,
  input  logic           dir_up_i,
  output logic [W-1:0]   buf_o,
  output logic [W-1:0]   act_o,
  output logic           match_o,
  output logic           oc_o
);
  import tc8_pkg::*;

  logic [W-1:0] buf_q, act_q;
  logic         oc_q;

  assign match_o = step_i & ~blk_i & (cnt_i == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_buf_i) buf_q <= wdata_i;
      if (!is_pwm(mode_i)) act_q <= wr_buf_i ? wdata_i : buf_q;
      else if (top_i)      act_q <= buf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q <= 1'b0;
    end else begin
      case (mode_i)
        MODE_FAST: begin
          if (top_i)        oc_q <= 1'b1;
          else if (match_o) oc_q <= 1'b0;
        end
        MODE_UPDN: if (match_o) oc_q <= dir_up_i;
        default:   if (match_o) oc_q <= ~oc_q;
      endcase
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;
  assign oc_o  = oc_q;
endmodule

// File: rtl/tc8_timer.sv
module tc8_timer #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         tick_i,
  input  logic         ext_i,
  output logic [1:0]   oc_o,
  output logic         irq_o
);
  import tc8_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [FLG_W-1:0]  flags_q, mask_q, set_evt, clr_req;
  logic              blk_q;
  mode_e             mode;
  logic              adv, cnt_wr, step, top_evt, ovf_evt, dir_up;
  logic [W-1:0]      cnt;
  logic [W-1:0]      buf_v [NUM_CH];
  logic [W-1:0]      act   [NUM_CH];
  logic [NUM_CH-1:0] match, wr_buf;

  assign mode   = mode_e'(ctrl_q[4:3]);
  assign cnt_wr = wr_en_i && (addr_i == ADDR_CNT);

  tc8_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (ctrl_q[2:0]),
    .tick_i(tick_i),
    .ext_i (ext_i),
    .adv_o (adv)
  );

  tc8_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .wr_i     (cnt_wr),
    .wdata_i  (wdata_i),
    .mode_i   (mode),
    .cmp_top_i(act[0]),
    .cnt_o    (cnt),
    .dir_up_o (dir_up),
    .step_o   (step),
    .top_o    (top_evt),
    .ovf_o    (ovf_evt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [2:0] CH_ADDR = ADDR_CMPA + 3'(g);
    assign wr_buf[g] = wr_en_i && (addr_i == CH_ADDR);
    tc8_cmp_chan #(.W(W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (mode),
      .wr_buf_i(wr_buf[g]),
      .wdata_i (wdata_i),
      .step_i  (step),
      .top_i   (top_evt),
      .blk_i   (blk_q),
      .cnt_i   (cnt),
      .dir_up_i(dir_up),
      .buf_o   (buf_v[g]),
      .act_o   (act[g]),
      .match_o (match[g]),
      .oc_o    (oc_o[g])
    );
  end

  // match suppression after a count write lasts until the next tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     blk_q <= 1'b0;
    else if (cnt_wr) blk_q <= 1'b1;
    else if (adv)    blk_q <= 1'b0;
  end

  assign set_evt = {match, ovf_evt};
  assign clr_req = (wr_en_i && addr_i == ADDR_FLAG) ? wdata_i[FLG_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_en_i && addr_i == ADDR_MASK) mask_q <= wdata_i[FLG_W-1:0];
      flags_q <= (flags_q & ~clr_req) | set_evt;
    end
  end

  assign irq_o = |(flags_q & mask_q);

  always_comb begin
    case (addr_i)
      ADDR_CNT:  rdata_o = cnt;
      ADDR_CMPA: rdata_o = buf_v[0];
      ADDR_CMPB: rdata_o = buf_v[1];
      ADDR_CTRL: rdata_o = W'(ctrl_q);
      ADDR_FLAG: rdata_o = W'(flags_q);
      ADDR_MASK: rdata_o = W'(mask_q);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tc8_timer_chk.sv
module tc8_timer_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [2:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic [4:0]   ctrl_i,
  input logic [W-1:0] cnt_i,
  input logic         dir_up_i,
  input logic         step_i,
  input logic         top_i,
  input logic         ovf_i,
  input logic [2:0]   flags_i,
  input logic [W-1:0] act_a_i
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic cnt_wr, none_sel;
  assign cnt_wr   = wr_en_i && addr_i == 3'd0;
  assign none_sel = (ctrl_i[2:0] == 3'd0) || ctrl_i[2];

  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (none_sel && !cnt_wr) |=> cnt_i == $past(cnt_i));

  assert_wr_prio_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt_i == $past(wdata_i));

  assert_up_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && ctrl_i[4:3] != 2'd3) |=> (cnt_i == W'($past(cnt_i) + ONE)) || (cnt_i == '0));

  assert_turn_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && ctrl_i[4:3] == 2'd3 && dir_up_i && cnt_i == MAX) |=> (cnt_i == MAX - ONE) && !dir_up_i);

  assert_ovf_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flags_i[0]);

  assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd4 && wdata_i[2:0] == 3'b111 && !step_i) |=> flags_i == 3'b000);

  assert_pwm_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[4] && !top_i && !(wr_en_i && addr_i == 3'd3)) |=> $stable(act_a_i));
endmodule

bind tc8_timer tc8_timer_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .ctrl_i  (ctrl_q),
  .cnt_i   (cnt),
  .dir_up_i(dir_up),
  .step_i  (step),
  .top_i   (top_evt),
  .ovf_i   (ovf_evt),
  .flags_i (flags_q),
  .act_a_i (act[0])
);

// File: tb/tc8_timer_test.sv
module tc8_timer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic       ext = 1'b0;
  logic [1:0] oc;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic ext_lvl = 1'b0;

  // reference state
  logic [7:0] m_cnt, m_bufa, m_bufb, m_acta, m_actb;
  logic [4:0] m_ctrl;
  logic [2:0] m_flags, m_mask;
  logic [1:0] m_oc;
  logic       m_dir, m_blk, m_s1, m_s2, m_s3;

  always #5 clk = ~clk;

  tc8_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .ext_i(ext),
    .oc_o(oc), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_bufa;
      3'd2: return m_bufb;
      3'd3: return {3'b0, m_ctrl};
      3'd4: return {5'b0, m_flags};
      3'd5: return {5'b0, m_mask};
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    {m_cnt, m_bufa, m_bufb, m_acta, m_actb} = '0;
    m_ctrl = '0; m_flags = '0; m_mask = '0; m_oc = '0;
    m_dir = 1'b1; m_blk = 1'b0; {m_s1, m_s2, m_s3} = '0;
  endtask

  task automatic m_step(input logic wr, input logic [2:0] a, input logic [7:0] d,
                        input logic tk, input logic ex);
    logic adv, cw, step, topev, ovf, ma, mb, nd;
    logic [7:0] nc, top;
    logic [1:0] mode;
    mode = m_ctrl[4:3];
    case (m_ctrl[2:0])
      3'd1: adv = tk;
      3'd2: adv = m_s2 & ~m_s3;
      3'd3: adv = ~m_s2 & m_s3;
      default: adv = 1'b0;
    endcase
    cw = wr && a == 3'd0;
    step = adv && !cw;
    top = (mode == 2'd1) ? m_acta : 8'hFF;
    nd = m_dir; topev = 1'b0; ovf = 1'b0;
    if (mode == 2'd3) begin
      if (m_dir) begin
        if (m_cnt == 8'hFF) begin nd = 1'b0; nc = 8'hFE; topev = 1'b1; end
        else nc = m_cnt + 8'd1;
      end else begin
        if (m_cnt == 8'h00) begin nd = 1'b1; nc = 8'h01; ovf = 1'b1; end
        else nc = m_cnt - 8'd1;
      end
    end else begin
      topev = (m_cnt == top);
      ovf = (m_cnt == 8'hFF);
      nc = (mode == 2'd1 && topev) ? 8'h00 : m_cnt + 8'd1;
    end
    topev = topev && step; ovf = ovf && step;
    ma = step && !m_blk && m_cnt == m_acta;
    mb = step && !m_blk && m_cnt == m_actb;
    // compare pins
    for (int c = 0; c < 2; c++) begin
      logic mt;
      mt = (c == 0) ? ma : mb;
      case (mode)
        2'd2: begin if (topev) m_oc[c] = 1'b1; else if (mt) m_oc[c] = 1'b0; end
        2'd3: if (mt) m_oc[c] = m_dir;
        default: if (mt) m_oc[c] = ~m_oc[c];
      endcase
    end
    // active compare
    if (!mode[1]) begin
      m_acta = (wr && a == 3'd1) ? d : m_bufa;
      m_actb = (wr && a == 3'd2) ? d : m_bufb;
    end else if (topev) begin
      m_acta = m_bufa;
      m_actb = m_bufb;
    end
    if (wr && a == 3'd1) m_bufa = d;
    if (wr && a == 3'd2) m_bufb = d;
    m_flags = (m_flags & ~((wr && a == 3'd4) ? d[2:0] : 3'b0)) | {mb, ma, ovf};
    if (wr && a == 3'd3) m_ctrl = d[4:0];
    if (wr && a == 3'd5) m_mask = d[2:0];
    if (cw) m_blk = 1'b1; else if (adv) m_blk = 1'b0;
    if (cw) m_cnt = d;
    else if (adv) begin m_cnt = nc; m_dir = nd; end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ex;
  endtask

  task automatic cyc(input logic wr, input logic [2:0] a, input logic [7:0] d,
                     input logic tk, input logic ex);
    @(negedge clk);
    wr_en = wr; addr = a; wdata = d; tick = tk; ext = ex; ext_lvl = ex;
    m_step(wr, a, d, tk, ex);
    @(posedge clk); #1;
    chk(a == 3'd0 ? "R4 count read" : "R2 register read", int'(rdata), int'(m_read(a)));
    chk("R10 compare pins", int'(oc), int'(m_oc));
    chk("R8 interrupt", int'(irq), int'(|(m_flags & m_mask)));
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, ext_lvl);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b1, ext_lvl);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    cyc(1'b0, a, 8'd0, 1'b0, ext_lvl);
    v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", int'(v), 0);
    end
    chk("R1 reset pins", int'({irq, oc}), 0);

    // R3 no source: ticks ignored
    ticks(5);
    rd(3'd0, v); chk("R3 frozen without source", int'(v), 0);
    wreg(3'd3, 8'h01);
    ticks(5);
    rd(3'd0, v); chk("R3 tick source", int'(v), 5);

    // R3 rising edge of ext, tick ignored
    wreg(3'd3, 8'h02);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1);
    chk("R3 sync latency", int'(rdata), 5);
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b1);
    chk("R3 rising edge counts", int'(rdata), 6);
    wreg(3'd3, 8'h03);
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b0);
    chk("R3 falling edge counts", int'(rdata), 7);

    // R4 clear on compare A
    wreg(3'd3, 8'h09);
    wreg(3'd1, 8'h03);
    wreg(3'd0, 8'h00);
    wreg(3'd4, 8'h07);
    ticks(4);
    rd(3'd0, v); chk("R4 clear at compare A", int'(v), 0);
    rd(3'd4, v); chk("R6 match A flag", int'(v[1]), 1);

    // R5 up/down turns
    wreg(3'd3, 8'h19);
    wreg(3'd0, 8'hFE);
    ticks(2);
    rd(3'd0, v); chk("R5 turn at top", int'(v), 8'hFE);
    wreg(3'd4, 8'h07);
    wreg(3'd0, 8'h01);
    ticks(2);
    rd(3'd0, v); chk("R5 turn at bottom", int'(v), 1);
    rd(3'd4, v); chk("R6 overflow at bottom turn", int'(v[0]), 1);

    // R8 mask gating
    wreg(3'd5, 8'h01);
    chk("R8 irq with mask", int'(irq), 1);
    wreg(3'd5, 8'h00);
    chk("R8 irq masked off", int'(irq), 0);

    // R7 write one to clear
    wreg(3'd4, 8'h07);
    rd(3'd4, v); chk("R7 flags cleared", int'(v), 0);

    // R11 write priority and match suppression
    wreg(3'd3, 8'h01);
    wreg(3'd1, 8'h05);
    wreg(3'd0, 8'h05);
    ticks(1);
    rd(3'd4, v); chk("R11 match suppressed", int'(v), 0);
    cyc(1'b1, 3'd0, 8'h05, 1'b1, ext_lvl);
    chk("R11 write beats tick", int'(rdata), 5);
    wreg(3'd0, 8'h04);
    ticks(2);
    rd(3'd4, v); chk("R11 match resumes", int'(v[1]), 1);

    // R9 buffered compare in fast PWM
    wreg(3'd3, 8'h11);
    wreg(3'd1, 8'h20);
    wreg(3'd4, 8'h07);
    wreg(3'd0, 8'h1F);
    ticks(2);
    rd(3'd4, v); chk("R9 buffer not yet active", int'(v[1]), 0);
    wreg(3'd0, 8'hFF);
    ticks(1);
    chk("R10 fast set at top", int'(oc[0]), 1);
    wreg(3'd4, 8'h07);
    ticks(8'h21);
    rd(3'd4, v); chk("R9 loaded at top", int'(v[1]), 1);
    chk("R10 fast clear on match", int'(oc[0]), 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic wr, tk, ex;
      logic [2:0] a;
      int r;
      wr = ($urandom % 6) == 0;
      r = $urandom % 16;
      if (wr) a = (r < 2) ? 3'd0 : (r < 5) ? 3'd1 : (r < 8) ? 3'd2 :
                  (r < 10) ? 3'd3 : (r < 13) ? 3'd4 : 3'd5;
      else a = 3'($urandom % 8);
      tk = $urandom % 2;
      ex = (($urandom % 4) == 0) ? ~ext_lvl : ext_lvl;
      cyc(wr, a, 8'($urandom), tk, ex);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule